// File: doc/BRIEF.md
# Aliased Control Register Bank for a Serial Port

This block is the software-visible register file of a serial port controller. It decodes a word-addressed bus with a single-cycle write strobe and a combinational read port. Six control registers sit behind it: three general control words, two line-control words and an interrupt word. Each of them answers at four consecutive word addresses. One address takes a plain write. The other three apply the written ones as a bit-set, a bit-clear or a bit-toggle, so firmware never has to read, modify and write a shared word.

Control word 0 carries two housekeeping bits. The soft-reset bit holds every other register at its reset value and clears itself after a fixed number of cycles, so firmware only needs to poll it until it reads zero. The clock-gate bit freezes every register except control word 0. The serial datapath is outside this block. It appears only as four event strobes that raise interrupt status bits, a received-byte input, a line-status input and a transmit-byte strobe. A single interrupt output combines each status bit with its enable bit.

Top module: `sio_ctrl_regs`

## Requirements
- R1: Word address bits [5:2] select the register: 0 = control 0, 1 = control 1, 2 = control 2, 3 = line control, 4 = line control 2, 5 = interrupt. Bits [1:0] select the access: 0 = plain, 1 = set, 2 = clear, 3 = toggle.
- R2: A plain write replaces the writable bits. A set write ORs the data in, a clear write clears the bits written as one, and a toggle write inverts them. Bits written as zero and bits outside the writable mask never change. The writable masks are: control 0 0x7FFF_FFFF, control 1 0x0000_FFFF, control 2 0xFFFF_FFFF, line control 0xFFFF_3F7F, line control 2 0xFFFF_FFFF, interrupt 0x0072_0072.
- R3: A read from any of the four addresses of an aliased register returns its current value.
- R4: After reset, control 0 reads 0xC000_0000 (soft reset and clock gate both set), control 2 reads 0x0000_0300 and the other aliased registers read 0.
- R5: Soft reset (control 0 bit 31) is one after reset, or after an idle-state write that makes it one. It stays one for SRST_CYCLES cycles and then clears itself. While it is one, every write is ignored and all other registers are held at their reset values.
- R6: While the clock gate (control 0 bit 30) is one, writes to every register other than control 0 are ignored, a data write raises no transmit strobe, and event strobes latch nothing.
- R7: In the interrupt register, enable bits 17, 20, 21 and 22 pair with status bits 1, 4, 5 and 6. Strobes evt_i[0..3] set status bits 1, 4, 5 and 6 respectively. A strobe wins over a clear of the same bit in the same cycle.
- R8: irq_o is one exactly when some status bit and its paired enable bit are both one. It follows the register with no added delay.
- R9: Word address 0x18 (data) reads rx_data_i zero-extended. A write there pulses tx_wr_o in the same cycle, with tx_data_o equal to wdata_i[7:0]. Word 0x1C reads stat_i and word 0x24 reads VERSION. None of these three has alias addresses.
- R10: Unmapped addresses, including the alias addresses of data, status and version, read zero. Writes to those addresses, to status and to version change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| evt_i | input | 4 | Datapath event strobes (CTS change, receive, transmit, receive timeout) |
| rx_data_i | input | 8 | Received byte for data reads |
| stat_i | input | 32 | Line status word |
| ctrl0_o | output | 32 | Control 0 value |
| ctrl1_o | output | 32 | Control 1 value |
| ctrl2_o | output | 32 | Control 2 value |
| line_o | output | 32 | Line control value |
| line2_o | output | 32 | Line control 2 value |
| irq_o | output | 1 | Interrupt request |
| tx_wr_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |

## Verification
The assertions take wr_i, addr_i and evt_i to be synchronous to clk_i and free of unknown values once reset is released. They treat a strobe held for several cycles as one event per cycle. The stimulus changes inputs only at falling edges and holds each write or event for exactly one rising edge. It places writes and events both inside and outside the soft-reset and clock-gate windows. It also issues one event in the same cycle as a clear of its own status bit.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned N_ALIASED = 6;
  localparam int unsigned N_EVT     = 4;

  localparam int unsigned IDX_CTRL0 = 0;
  localparam int unsigned IDX_CTRL1 = 1;
  localparam int unsigned IDX_CTRL2 = 2;
  localparam int unsigned IDX_LINE  = 3;
  localparam int unsigned IDX_LINE2 = 4;
  localparam int unsigned IDX_IRQ   = 5;
  localparam int unsigned IDX_DATA  = 6;
  localparam int unsigned IDX_STAT  = 7;
  localparam int unsigned IDX_VER   = 9;

  localparam int unsigned SRST_BIT  = 31;
  localparam int unsigned GATE_BIT  = 30;
  localparam int unsigned ENA_SHIFT = 16;

  // status bit fed by each event strobe, enable sits ENA_SHIFT above
  localparam int unsigned IRQ_POS [N_EVT] = '{1, 4, 5, 6};

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_SET = 2'd1,
    ACC_CLR = 2'd2,
    ACC_TOG = 2'd3
  } acc_e;

  function automatic logic [DATA_W-1:0] reg_wmask(int unsigned idx);
    case (idx)
      IDX_CTRL0: return 32'h7FFF_FFFF;
      IDX_CTRL1: return 32'h0000_FFFF;
      IDX_LINE:  return 32'hFFFF_3F7F;
      IDX_IRQ:   return 32'h0072_0072;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_rst(int unsigned idx);
    case (idx)
      IDX_CTRL0: return 32'h4000_0000;
      IDX_CTRL2: return 32'h0000_0300;
      default:   return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] apply_acc(acc_e op, logic [DATA_W-1:0] q,
                                                  logic [DATA_W-1:0] d,
                                                  logic [DATA_W-1:0] m);
    logic [DATA_W-1:0] dm;
    dm = d & m;
    case (op)
      ACC_SET: return q | dm;
      ACC_CLR: return q & ~dm;
      ACC_TOG: return q ^ dm;
      default: return (q & ~m) | dm;
    endcase
  endfunction
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output acc_e                 acc_o,
  output logic [N_ALIASED-1:0] alias_hit_o,
  output logic                 data_hit_o,
  output logic                 stat_hit_o,
  output logic                 ver_hit_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             plain;

  assign idx   = addr_i[ADDR_W-1:2];
  assign acc_o = acc_e'(addr_i[1:0]);
  assign plain = (addr_i[1:0] == 2'd0);

  for (genvar g = 0; g < N_ALIASED; g++) begin : g_hit
    assign alias_hit_o[g] = (idx == IDX_W'(g));
  end

  assign data_hit_o = plain && (idx == IDX_W'(IDX_DATA));
  assign stat_hit_o = plain && (idx == IDX_W'(IDX_STAT));
  assign ver_hit_o  = plain && (idx == IDX_W'(IDX_VER));
endmodule

// File: rtl/sio_alias_reg.sv
module sio_alias_reg
  import sio_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST   = '0,
  parameter logic [DATA_W-1:0] WMASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              we_i,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] hw_set_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q, q_d;

  // hardware set is ORed after the write so a same-cycle clear cannot lose an event
  always_comb begin
    q_d = we_i ? apply_acc(acc_i, q_q, wdata_i, WMASK) : q_q;
    q_d = q_d | (hw_set_i & WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= RST;
    else if (hold_i) q_q <= RST;
    else             q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sio_srst_ctl.sv
module sio_srst_ctl
  import sio_regs_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  acc_e acc_i,
  input  logic bit_i,
  output logic srst_o
);
  localparam int unsigned CW = $clog2(SRST_CYCLES + 1);

  logic          srst_q;
  logic [CW-1:0] cnt_q;
  logic          req;

  always_comb begin
    case (acc_i)
      ACC_CLR: req = 1'b0;
      default: req = bit_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b1;
      cnt_q  <= '0;
    end else if (srst_q) begin
      if (cnt_q == CW'(SRST_CYCLES - 1)) begin
        srst_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (we_i && req) begin
      srst_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign srst_o = srst_q;

  AST_SRST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_q && !we_i) |=> !srst_q); // R5
  AST_SRST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |-> (cnt_q < CW'(SRST_CYCLES))); // R5
endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_regs_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 6,
  parameter int unsigned       SRST_CYCLES = 4,
  parameter logic [DATA_W-1:0] VERSION     = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [7:0]        rx_data_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] ctrl0_o,
  output logic [DATA_W-1:0] ctrl1_o,
  output logic [DATA_W-1:0] ctrl2_o,
  output logic [DATA_W-1:0] line_o,
  output logic [DATA_W-1:0] line2_o,
  output logic              irq_o,
  output logic              tx_wr_o,
  output logic [7:0]        tx_data_o
);
  acc_e                 acc;
  logic [N_ALIASED-1:0] alias_hit;
  logic                 data_hit, stat_hit, ver_hit;
  logic                 srst, gate;
  logic [DATA_W-1:0]    reg_q [N_ALIASED];
  logic [DATA_W-1:0]    shown [N_ALIASED];
  logic [DATA_W-1:0]    evt_vec;

  sio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i      (addr_i),
    .acc_o       (acc),
    .alias_hit_o (alias_hit),
    .data_hit_o  (data_hit),
    .stat_hit_o  (stat_hit),
    .ver_hit_o   (ver_hit)
  );

  sio_srst_ctl #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && alias_hit[IDX_CTRL0]),
    .acc_i  (acc),
    .bit_i  (wdata_i[SRST_BIT]),
    .srst_o (srst)
  );

  assign gate = reg_q[IDX_CTRL0][GATE_BIT];

  always_comb begin
    evt_vec = '0;
    for (int k = 0; k < N_EVT; k++) evt_vec[IRQ_POS[k]] = evt_i[k] && !gate && !srst;
  end

  for (genvar g = 0; g < N_ALIASED; g++) begin : g_reg
    logic we;
    logic [DATA_W-1:0] hw_set;
    // control 0 stays writable under the clock gate so firmware can lift it
    if (g == IDX_CTRL0) begin : g_ungated
      assign we = wr_i && alias_hit[g] && !srst;
    end else begin : g_gated
      assign we = wr_i && alias_hit[g] && !srst && !gate;
    end
    if (g == IDX_IRQ) begin : g_evt
      assign hw_set = evt_vec;
    end else begin : g_noevt
      assign hw_set = '0;
    end

    sio_alias_reg #(.RST(reg_rst(g)), .WMASK(reg_wmask(g))) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (srst),
      .we_i     (we),
      .acc_i    (acc),
      .wdata_i  (wdata_i),
      .hw_set_i (hw_set),
      .q_o      (reg_q[g])
    );
  end

  always_comb begin
    for (int i = 0; i < N_ALIASED; i++) shown[i] = reg_q[i];
    shown[IDX_CTRL0][SRST_BIT] = reg_q[IDX_CTRL0][SRST_BIT] | srst;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_ALIASED; i++) if (alias_hit[i]) rdata_o = shown[i];
    if (data_hit) rdata_o = {{(DATA_W-8){1'b0}}, rx_data_i};
    if (stat_hit) rdata_o = stat_i;
    if (ver_hit)  rdata_o = VERSION;
  end

  always_comb begin
    irq_o = 1'b0;
    for (int k = 0; k < N_EVT; k++)
      irq_o = irq_o | (reg_q[IDX_IRQ][IRQ_POS[k]] & reg_q[IDX_IRQ][IRQ_POS[k] + ENA_SHIFT]);
  end

  assign tx_wr_o   = wr_i && data_hit && !srst && !gate;
  assign tx_data_o = wdata_i[7:0];

  assign ctrl0_o = shown[IDX_CTRL0];
  assign ctrl1_o = shown[IDX_CTRL1];
  assign ctrl2_o = shown[IDX_CTRL2];
  assign line_o  = shown[IDX_LINE];
  assign line2_o = shown[IDX_LINE2];

  AST_HOLD_IN_SRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ctrl2_o == reg_rst(IDX_CTRL2)) && (line_o == '0)); // R5
  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && !srst) |=> $stable(reg_q[IDX_CTRL1])); // R6
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[2] && !gate && !srst) |=> reg_q[IDX_IRQ][5]); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reg_q[IDX_IRQ][22:16] != 7'd0)); // R8
endmodule

// File: tb/sio_ctrl_regs_tb.sv
module sio_ctrl_regs_tb;
  localparam int SR = 4;
  localparam logic [31:0] VER = 32'h0002_0301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  evt = '0;
  logic [7:0]  rx_data = '0;
  logic [31:0] stat = '0;
  logic [31:0] c0, c1, c2, l1, l2;
  logic        irq, tx_wr;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_ctrl_regs #(.ADDR_W(6), .SRST_CYCLES(SR), .VERSION(VER)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .rx_data_i(rx_data), .stat_i(stat),
    .ctrl0_o(c0), .ctrl1_o(c1), .ctrl2_o(c2), .line_o(l1), .line2_o(l2),
    .irq_o(irq), .tx_wr_o(tx_wr), .tx_data_o(tx_data)
  );

  // behavioural reference model
  logic [31:0] mask [6] = '{32'h7FFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF,
                            32'hFFFF_3F7F, 32'hFFFF_FFFF, 32'h0072_0072};
  logic [31:0] rstv [6] = '{32'h4000_0000, 32'h0, 32'h0000_0300, 32'h0, 32'h0, 32'h0};
  logic [31:0] m [6];
  logic [31:0] nx [6];
  logic        m_srst;
  int          m_cnt;
  int          w_idx, w_acc;
  logic [31:0] dm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m[i] = rstv[i];
      m_srst = 1'b1;
      m_cnt  = 0;
    end else begin
      for (int i = 0; i < 6; i++) nx[i] = m[i];
      if (m_srst) begin
        for (int i = 0; i < 6; i++) nx[i] = rstv[i];
        if (m_cnt == SR - 1) begin m_srst = 1'b0; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (wr) begin
          w_idx = int'(addr) / 4;
          w_acc = int'(addr) % 4;
          if (w_idx < 6 && (w_idx == 0 || !m[0][30])) begin
            dm = wdata & mask[w_idx];
            case (w_acc)
              0: nx[w_idx] = (m[w_idx] & ~mask[w_idx]) | dm;
              1: nx[w_idx] = m[w_idx] | dm;
              2: nx[w_idx] = m[w_idx] & ~dm;
              default: nx[w_idx] = m[w_idx] ^ dm;
            endcase
            if (w_idx == 0 && w_acc != 2 && wdata[31]) begin m_srst = 1'b1; m_cnt = 0; end
          end
        end
        if (!m[0][30]) begin
          if (evt[0]) nx[5][1] = 1'b1;
          if (evt[1]) nx[5][4] = 1'b1;
          if (evt[2]) nx[5][5] = 1'b1;
          if (evt[3]) nx[5][6] = 1'b1;
        end
      end
      for (int i = 0; i < 6; i++) m[i] = nx[i];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every cycle: register outputs and irq against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 ctrl0", c0, {m_srst, m[0][30:0]});
      chk("R2 ctrl1", c1, m[1]);
      chk("R2 ctrl2", c2, m[2]);
      chk("R2 line", l1, m[3]);
      chk("R2 line2", l2, m[4]);
      chk("R8 irq", {31'b0, irq}, {31'b0, |(m[5][6:0] & m[5][22:16] & 7'h72)});
    end
  end

  task automatic wr_ev(logic [5:0] a, logic [31:0] d, logic [3:0] ev);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; evt = ev;
    @(posedge clk); #1;
    wr = 1'b0; evt = '0;
  endtask

  task automatic wr_tx(logic [5:0] a, logic [31:0] d, logic exp_wr, string tag);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1;
    chk(tag, {31'b0, tx_wr}, {31'b0, exp_wr});
    if (exp_wr) chk(tag, {24'b0, tx_data}, {24'b0, d[7:0]});
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic pulse(logic [3:0] ev);
    @(negedge clk);
    evt = ev;
    @(posedge clk); #1;
    evt = '0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R4 reset state, read while the power-on soft reset still runs
    rd(6'h00, 32'hC000_0000, "R4 ctrl0 reset");
    rd(6'h08, 32'h0000_0300, "R4 ctrl2 reset");
    rd(6'h14, 32'h0, "R4 irq reset");
    idle(SR + 2);
    rd(6'h00, 32'h4000_0000, "R5 self clear");
    // R6 gate blocks writes, data strobe and events
    wr_ev(6'h04, 32'h0000_1234, 4'b0);
    rd(6'h04, 32'h0, "R6 gated write");
    wr_tx(6'h18, 32'h0000_00A5, 1'b0, "R6 gated tx");
    pulse(4'hF);
    rd(6'h14, 32'h0, "R6 gated evt");
    // R2 clear gate through control 0 clear alias
    wr_ev(6'h02, 32'h4000_0000, 4'b0);
    rd(6'h00, 32'h0, "R2 ctrl0 clr");
    wr_ev(6'h04, 32'hABCD_1234, 4'b0);
    rd(6'h04, 32'h0000_1234, "R2 ctrl1 mask");
    // R1 alias selection on control 2
    wr_ev(6'h09, 32'h0000_0001, 4'b0);
    rd(6'h08, 32'h0000_0301, "R1 set");
    wr_ev(6'h0A, 32'h0000_0100, 4'b0);
    rd(6'h08, 32'h0000_0201, "R1 clr");
    wr_ev(6'h0B, 32'h0000_0003, 4'b0);
    rd(6'h08, 32'h0000_0202, "R1 tog");
    rd(6'h09, 32'h0000_0202, "R3 set alias read");
    rd(6'h0B, 32'h0000_0202, "R3 tog alias read");
    wr_ev(6'h0C, 32'hFFFF_FFFF, 4'b0);
    rd(6'h0E, 32'hFFFF_3F7F, "R2 line mask");
    wr_ev(6'h0B, 32'h0, 4'b0);
    rd(6'h08, 32'h0000_0202, "R2 zero tog");
    wr_ev(6'h10, 32'h8765_4321, 4'b0);
    rd(6'h11, 32'h8765_4321, "R3 line2");
    // R7/R8 interrupts
    wr_ev(6'h15, 32'h0002_0000, 4'b0);
    rd(6'h14, 32'h0002_0000, "R7 cts enable");
    pulse(4'b0001);
    rd(6'h14, 32'h0002_0002, "R7 cts status");
    chk("R8 irq set", {31'b0, irq}, 32'd1);
    wr_ev(6'h16, 32'h0000_0002, 4'b0);
    rd(6'h14, 32'h0002_0000, "R7 ack");
    chk("R8 irq ack", {31'b0, irq}, 32'd0);
    pulse(4'b0010);
    chk("R8 no enable", {31'b0, irq}, 32'd0);
    wr_ev(6'h16, 32'h0000_0010, 4'b0010);
    rd(6'h14, 32'h0002_0010, "R7 evt beats clr");
    wr_ev(6'h15, 32'h0010_0000, 4'b0);
    chk("R8 rx irq", {31'b0, irq}, 32'd1);
    pulse(4'b1100);
    rd(6'h14, 32'h0012_0070, "R7 tx rt status");
    wr_ev(6'h14, 32'hFFFF_FFFF, 4'b0);
    rd(6'h14, 32'h0072_0072, "R2 irq mask");
    // R9 data, status, version
    rx_data = 8'h5A;
    rd(6'h18, 32'h0000_005A, "R9 rx read");
    wr_tx(6'h18, 32'h0000_01C3, 1'b1, "R9 tx strobe");
    stat = 32'hDEAD_BEEF;
    rd(6'h1C, 32'hDEAD_BEEF, "R9 status");
    rd(6'h24, VER, "R9 version");
    // R10 unmapped and read-only
    rd(6'h19, 32'h0, "R10 data alias");
    rd(6'h1D, 32'h0, "R10 status alias");
    rd(6'h28, 32'h0, "R10 unmapped");
    rd(6'h3F, 32'h0, "R10 top");
    wr_tx(6'h1A, 32'h0000_0077, 1'b0, "R10 data alias write");
    wr_ev(6'h1C, 32'hFFFF_FFFF, 4'b0);
    wr_ev(6'h24, 32'hFFFF_FFFF, 4'b0);
    wr_ev(6'h2D, 32'hFFFF_FFFF, 4'b0);
    rd(6'h04, 32'h0000_1234, "R10 ctrl1 untouched");
    rd(6'h24, VER, "R10 version untouched");
    // R5 software soft reset
    wr_ev(6'h01, 32'h8000_0000, 4'b0);
    rd(6'h00, 32'h8000_0000, "R5 srst set");
    rd(6'h08, 32'h0000_0300, "R5 hold ctrl2");
    wr_ev(6'h04, 32'h0000_FFFF, 4'b0);
    rd(6'h04, 32'h0, "R5 write ignored");
    idle(SR + 2);
    rd(6'h00, 32'h4000_0000, "R5 srst done");
    rd(6'h14, 32'h0, "R5 irq reset");
    chk("R5 irq low", {31'b0, irq}, 32'd0);
    // R5 toggle start, clear attempt ignored mid window
    wr_ev(6'h02, 32'h4000_0000, 4'b0);
    wr_ev(6'h03, 32'h8000_0000, 4'b0);
    wr_ev(6'h02, 32'h8000_0000, 4'b0);
    rd(6'h00, 32'hC000_0000, "R5 clr during window");
    idle(SR + 2);
    rd(6'h00, 32'h4000_0000, "R5 tog done");
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule